// File: doc/BRIEF.md
# Privileged Interrupt Priority Arbiter

This block sits at the retire end of a processor pipeline and decides, each time an instruction has fully completed, whether one of the six standard interrupts is taken and which one. It reads the current privilege level, the machine and supervisor global enable bits, and the pending, enable and delegation vectors. From these it computes which interrupts are eligible for machine mode and which for supervisor mode. Because the decision is made only at a retire boundary, the saved program counter of the trap sequence points at the next instruction that has not yet executed.

The arbiter applies the global enable rule relative to the target mode. An interrupt aimed at a more privileged mode than the current one is always allowed. An interrupt aimed at the current mode follows that mode's enable bit. An interrupt aimed at a less privileged mode is never allowed. Among the eligible interrupts it picks one by a fixed order that is not numeric. One cycle after the retire strobe it presents a take pulse, the cause word with the interrupt flag in the top bit, the target mode, and a one-hot mask that the pending register uses to clear the bit that was taken.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset `take_o` and `to_s_o` are 0 and `cause_o` and `clr_mask_o` are all zero. Whenever `take_o` is 0, `cause_o` and `clr_mask_o` are zero.
- R2: `take_o` is high in the cycle after a cycle in which `retire_i` was high and an interrupt was eligible. It is never high without a retire in the previous cycle.
- R3: An interrupt aimed at machine mode (delegation bit 0) is not taken while `priv_i` is machine (3) and `m_gie_i` is 0. It is taken when `m_gie_i` is 1.
- R4: An interrupt aimed at machine mode is taken while `priv_i` is user (0) or supervisor (1), whatever the value of `m_gie_i`.
- R5: An interrupt aimed at supervisor mode (delegation bit 1) is taken in supervisor mode only when `s_gie_i` is 1. It is always taken in user mode and never taken in machine mode.
- R6: An interrupt is eligible only when its bit is set in both `pend_i` and `en_i`.
- R7: Within a target mode the priority from highest to lowest is external-M (bit 11), software-M (bit 3), timer-M (bit 7), external-S (bit 9), software-S (bit 1), timer-S (bit 5).
- R8: Any eligible interrupt aimed at machine mode wins over every eligible interrupt aimed at supervisor mode.
- R9: On a take, `cause_o` equals the selected bit number (1, 3, 5, 7, 9 or 11) with bit 63 set.
- R10: On a take, `clr_mask_o` has exactly one bit set, at the position of the selected interrupt.
- R11: On a take, `to_s_o` is 1 when the selected interrupt is delegated to supervisor mode and 0 when it goes to machine mode.
- R12: Bits of `pend_i`, `en_i` and `deleg_i` other than 1, 3, 5, 7, 9 and 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| retire_i | input | 1 | An instruction has fully completed this cycle |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| pend_i | input | 64 | Pending interrupt bits |
| en_i | input | 64 | Per-interrupt enable bits |
| deleg_i | input | 64 | Delegation bits; 1 sends the interrupt to supervisor mode |
| take_o | output | 1 | One-cycle pulse: an interrupt is taken |
| cause_o | output | 64 | Cause word with interrupt flag in bit 63 |
| to_s_o | output | 1 | Target mode of the taken interrupt: 1 supervisor, 0 machine |
| clr_mask_o | output | 64 | One-hot clear mask for the taken pending bit |

## Verification
The bench concentrates on the global enable rule at each privilege level. A design that compared privilege the wrong way round would take machine interrupts with the enable clear in machine mode, or drop them in user mode. It would also deliver delegated interrupts while running in machine mode. The bench walks the full priority chain by removing the winner one step at a time, so a design that ordered by bit number would report timer-M before software-M. It then pits a low-priority machine interrupt against a delegated machine-external one, which catches a design that merged the two targets into one priority list. Stray bits set everywhere outside the six sources check that a wider decode would not fire falsely.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_M = 2'd3
    } priv_e;

    localparam int NUM_SRC   = 6;
    localparam int SRC_IDX_W = $clog2(NUM_SRC);

    // Rank 0 is the highest priority; the result is the bit position,
    // which equals the cause number.
    function automatic int src_bit(input int rank);
        case (rank)
            0:       return 11;
            1:       return 3;
            2:       return 7;
            3:       return 9;
            4:       return 1;
            default: return 5;
        endcase
    endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_arb_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [1:0]         priv_i,
    input  logic               m_gie_i,
    input  logic               s_gie_i,
    input  logic [XLEN-1:0]    pend_i,
    input  logic [XLEN-1:0]    en_i,
    input  logic [XLEN-1:0]    deleg_i,
    output logic [NUM_SRC-1:0] m_elig_o,
    output logic [NUM_SRC-1:0] s_elig_o
);

    logic m_glob;
    logic s_glob;

    // Target above current level: on. Same level: its enable bit. Below: off.
    always_comb begin
        m_glob = (priv_i != PRIV_M) || m_gie_i;
        s_glob = (priv_i == PRIV_U) || ((priv_i == PRIV_S) && s_gie_i);
    end

    for (genvar r = 0; r < NUM_SRC; r++) begin : g_src
        localparam int B = src_bit(r);
        logic live;
        assign live        = pend_i[B] & en_i[B];
        assign m_elig_o[r] = live & ~deleg_i[B] & m_glob;
        assign s_elig_o[r] = live &  deleg_i[B] & s_glob;
    end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N = 6,
    localparam int W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0] req_i,
    output logic         hit_o,
    output logic [W-1:0] idx_o
);

    // Index 0 wins: scan downward so the last match is the lowest index.
    always_comb begin
        hit_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                hit_o = 1'b1;
                idx_o = W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
    import irq_arb_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            retire_i,
    input  logic [1:0]      priv_i,
    input  logic            m_gie_i,
    input  logic            s_gie_i,
    input  logic [XLEN-1:0] pend_i,
    input  logic [XLEN-1:0] en_i,
    input  logic [XLEN-1:0] deleg_i,
    output logic            take_o,
    output logic [XLEN-1:0] cause_o,
    output logic            to_s_o,
    output logic [XLEN-1:0] clr_mask_o
);

    localparam logic [XLEN-1:0] IRQ_FLAG = XLEN'(1) << (XLEN - 1);

    typedef struct packed {
        logic            take;
        logic            to_s;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] clr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [NUM_SRC-1:0]   m_elig, s_elig;
    logic                 m_hit, s_hit;
    logic [SRC_IDX_W-1:0] m_idx, s_idx;

    irq_gate #(.XLEN(XLEN)) u_gate (
        .priv_i   (priv_i),
        .m_gie_i  (m_gie_i),
        .s_gie_i  (s_gie_i),
        .pend_i   (pend_i),
        .en_i     (en_i),
        .deleg_i  (deleg_i),
        .m_elig_o (m_elig),
        .s_elig_o (s_elig)
    );

    irq_pick #(.N(NUM_SRC)) u_pick_m (
        .req_i (m_elig),
        .hit_o (m_hit),
        .idx_o (m_idx)
    );

    irq_pick #(.N(NUM_SRC)) u_pick_s (
        .req_i (s_elig),
        .hit_o (s_hit),
        .idx_o (s_idx)
    );

    always_comb begin
        int sel_bit;
        st_d    = '0;
        sel_bit = 0;
        if (retire_i) begin
            if (m_hit) begin
                st_d.take = 1'b1;
                sel_bit   = src_bit(int'(m_idx));
            end else if (s_hit) begin
                st_d.take = 1'b1;
                st_d.to_s = 1'b1;
                sel_bit   = src_bit(int'(s_idx));
            end
        end
        if (st_d.take) begin
            st_d.cause = XLEN'(sel_bit) | IRQ_FLAG;
            st_d.clr   = XLEN'(1) << sel_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o     = st_q.take;
    assign to_s_o     = st_q.to_s;
    assign cause_o    = st_q.cause;
    assign clr_mask_o = st_q.clr;

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0 && clr_mask_o == '0 && !to_s_o));

    assert_take_needs_retire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> $past(retire_i));

    assert_sup_never_from_m_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && to_s_o) |-> ($past(priv_i) != PRIV_M));

    assert_cause_matches_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cause_o[XLEN-1] && clr_mask_o == (XLEN'(1) << cause_o[5:0])));

    assert_mask_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ($countones(clr_mask_o) == 1));

    assert_target_follows_deleg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (to_s_o == |($past(deleg_i) & clr_mask_o)));

    assert_grant_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((($past(pend_i) & $past(en_i)) & clr_mask_o) == clr_mask_o));

endmodule

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_i = 1'b0;
    logic [1:0]  priv_i = 2'd0;
    logic        m_gie_i = 1'b0;
    logic        s_gie_i = 1'b0;
    logic [63:0] pend_i = '0;
    logic [63:0] en_i = '0;
    logic [63:0] deleg_i = '0;
    logic        take_o;
    logic [63:0] cause_o;
    logic        to_s_o;
    logic [63:0] clr_mask_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [1:0] PU = 2'd0, PS = 2'd1, PM = 2'd3;
    localparam logic [63:0] SIX = 64'hAAA;

    always #2 clk = ~clk;

    irq_prio_arbiter u_irq_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .priv_i(priv_i),
        .m_gie_i(m_gie_i), .s_gie_i(s_gie_i), .pend_i(pend_i), .en_i(en_i),
        .deleg_i(deleg_i), .take_o(take_o), .cause_o(cause_o),
        .to_s_o(to_s_o), .clr_mask_o(clr_mask_o)
    );

    function automatic logic [63:0] bt(input int n);
        return 64'd1 << n;
    endfunction

    task automatic expect_out(input string req, input bit e_take,
                              input bit e_s, input int code);
        logic [63:0] e_cause, e_clr;
        e_cause = e_take ? (64'(code) | (64'd1 << 63)) : 64'd0;
        e_clr   = e_take ? bt(code) : 64'd0;
        n_chk++;
        if (take_o !== e_take || to_s_o !== (e_take & e_s) ||
            cause_o !== e_cause || clr_mask_o !== e_clr) begin
            n_bad++;
            $display("FAIL %s: take=%0b to_s=%0b cause=%h clr=%h expected take=%0b to_s=%0b cause=%h clr=%h",
                     req, take_o, to_s_o, cause_o, clr_mask_o,
                     e_take, e_take & e_s, e_cause, e_clr);
        end
    endtask

    task automatic fire(input logic [1:0] pv, input bit mg, input bit sg,
                        input logic [63:0] p, input logic [63:0] e,
                        input logic [63:0] d, input bit ret);
        @(negedge clk);
        priv_i = pv; m_gie_i = mg; s_gie_i = sg;
        pend_i = p; en_i = e; deleg_i = d; retire_i = ret;
        @(posedge clk);
        @(negedge clk);
        retire_i = 1'b0;
    endtask

    task automatic t_reset();
        expect_out("R1", 0, 0, 0);
    endtask

    task automatic t_no_retire();
        fire(PU, 1, 1, bt(11), bt(11), '0, 0);
        expect_out("R2", 0, 0, 0);
        fire(PU, 1, 1, bt(11), bt(11), '0, 1);
        expect_out("R2", 1, 0, 11);
        @(posedge clk); @(negedge clk);
        expect_out("R2", 0, 0, 0);
    endtask

    task automatic t_machine_enable();
        fire(PM, 0, 1, bt(7), bt(7), '0, 1);
        expect_out("R3", 0, 0, 0);
        fire(PM, 1, 0, bt(7), bt(7), '0, 1);
        expect_out("R3", 1, 0, 7);
    endtask

    task automatic t_lower_priv();
        fire(PU, 0, 0, bt(3), bt(3), '0, 1);
        expect_out("R4", 1, 0, 3);
        fire(PS, 0, 0, bt(11), bt(11), '0, 1);
        expect_out("R4", 1, 0, 11);
    endtask

    task automatic t_delegated();
        fire(PS, 1, 0, bt(9), bt(9), bt(9), 1);
        expect_out("R5", 0, 0, 0);
        fire(PS, 0, 1, bt(9), bt(9), bt(9), 1);
        expect_out("R5 R11", 1, 1, 9);
        fire(PU, 0, 0, bt(9), bt(9), bt(9), 1);
        expect_out("R5", 1, 1, 9);
        fire(PM, 1, 1, bt(9), bt(9), bt(9), 1);
        expect_out("R5", 0, 0, 0);
    endtask

    task automatic t_enable_pend();
        fire(PU, 1, 1, bt(11), '0, '0, 1);
        expect_out("R6", 0, 0, 0);
        fire(PU, 1, 1, '0, bt(11), '0, 1);
        expect_out("R6", 0, 0, 0);
    endtask

    task automatic t_priority();
        int order [6] = '{11, 3, 7, 9, 1, 5};
        logic [63:0] p = SIX;
        for (int k = 0; k < 6; k++) begin
            fire(PU, 0, 0, p, SIX, '0, 1);
            expect_out("R7 R9 R10", 1, 0, order[k]);
            p &= ~bt(order[k]);
        end
    endtask

    task automatic t_target_order();
        fire(PS, 0, 1, bt(11) | bt(5), SIX, bt(11), 1);
        expect_out("R8 R11", 1, 0, 5);
        fire(PU, 0, 0, SIX, SIX, SIX, 1);
        expect_out("R8 R11", 1, 1, 11);
        fire(PU, 0, 0, bt(1) | bt(5), SIX, bt(1), 1);
        expect_out("R8", 1, 0, 5);
    endtask

    task automatic t_foreign_bits();
        fire(PU, 1, 1, ~SIX, ~SIX, ~SIX, 1);
        expect_out("R12", 0, 0, 0);
        fire(PU, 1, 1, ~64'd0, SIX | 64'h1, ~SIX, 1);
        expect_out("R12", 1, 0, 11);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_retire();
        t_machine_enable();
        t_lower_priv();
        t_delegated();
        t_enable_pend();
        t_priority();
        t_target_order();
        t_foreign_bits();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule